// File: doc/BRIEF.md
# Serial Register Access Slave with Selectable Output Edge

This block lets an external host read and write a small internal register file over four wires: an active-low chip select, a shift clock, a serial data input and a serial data output. A fifth input, a board-level strap, decides on which shift-clock edge the slave moves its output to the next bit. All pin activity is brought into the system clock domain through two-flop synchronisers, and the shift-clock and chip-select edges are detected there. The shift clock must therefore run several times slower than the system clock.

A transaction opens when chip select falls and runs for 16 shift-clock periods. The first bit is a direction flag, where 1 means read. The next 7 bits are the register address and the last 8 bits are data, each field sent most significant bit first. Every input bit is taken on a rising shift-clock edge.

For a write, the data byte is stored once the sixteenth bit has arrived. For a read, the addressed register is captured as soon as the last address bit is in, and is then returned on the output pin. The output pin is released (high impedance) except during the data phase of a read, and a pad enable is also provided. If chip select rises before the frame is complete, the transaction is abandoned and no register changes.

Top module: `sreg_slave`

## Requirements
- R1: After reset, the output enable is low and every register reads back as 0x00.
- R2: A frame whose first bit is 0 writes its 8 data bits, MSB first, into the register named by the 7-bit address that follows the flag. The write takes effect after the 16th rising shift-clock edge.
- R3: A frame whose first bit is 1 returns the contents of the addressed register, MSB first, on the data output. Addresses 0x00 and 0x7F are both reachable.
- R4: With the strap low, data bit k (k = 0 is the MSB) appears after rising edge 8+k and stays unchanged until the next rising edge. The host samples it on the falling edge that follows.
- R5: With the strap high, the MSB appears after rising edge 8. Every later bit changes only after a falling edge, so bit k is valid at rising edge 9+k.
- R6: The output enable goes high only during the data phase of a read, that is, after the 8th rising edge of a read frame. It drops once chip select is high. It stays low throughout a write frame.
- R7: If chip select rises before all 16 bits have been received, the transaction is aborted and no register is written.
- R8: Shift-clock activity while chip select is high has no effect. A transaction starts only on a high-to-low transition of chip select.
- R9: Shift-clock edges beyond the 16th within the same chip-select window are ignored. They cause no second write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Host shift clock |
| sdi | input | 1 | Serial data from the host, sampled on rising shift-clock edges |
| out_edge_fall | input | 1 | Strap: 1 updates data out on falling edges, 0 on rising edges |
| sdo | output | 1 | Serial data to the host, high impedance outside read data phases |
| sdo_oe | output | 1 | Pad enable for sdo, high while read data is being driven |

## Verification
The bench reads the same registers under both strap settings, sampling each bit at the last moment before the edge on which the host would take it. A design that moved its output on the wrong edge, or one edge early or late, returns a shifted byte.

Writes are made to the lowest and highest addresses. A design that dropped the flag bit or misaligned the address field corrupts a neighbouring location.

Frames cut off after 8, 12 and 15 bits must leave the target register unchanged. A frame with extra clocks after the 16th must not write a second time. A frame clocked while chip select is high must do nothing, because a slave that counted edges without a select would overwrite data.

The output enable is checked in the middle of writes and after chip select rises.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // Frame sequencer states
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_DONE  = 2'd2
  } fr_state_e;

endpackage

// File: rtl/sreg_rst_sync.sv
// Reset conditioner: asserts asynchronously, releases on a clock edge.
module sreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/sreg_sync.sv
// Two-flop synchroniser bank with a per-bit reset value.
module sreg_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/sreg_edge.sv
// Edge detector on an already synchronised level.
module sreg_edge #(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/sreg_frame.sv
// Frame sequencer: header capture, write commit and read-data shifting.
module sreg_frame
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi_bit,
  input  logic              upd_on_fall,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo_bit,
  output logic              sdo_oe
);

  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int SR_W       = ((HDR_BITS > DATA_W) ? HDR_BITS : DATA_W) - 1;

  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_HDR      = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_FRM_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FRM_PEN  = CNT_W'(FRAME_BITS - 2);

  fr_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q,   cnt_n;
  logic [SR_W-1:0]   sr_q,    sr_n;
  logic              rw_q,    rw_n;
  logic [ADDR_W-1:0] addr_q,  addr_n;
  logic [DATA_W-1:0] tx_q,    tx_n;
  logic              bit_q,   bit_n;
  logic              oe_q,    oe_n;
  logic              we_q,    we_n;
  logic [DATA_W-1:0] wd_q,    wd_n;

  logic [HDR_BITS-1:0] hdr_full;
  logic [DATA_W-1:0]   data_full;
  logic                hdr_is_read;

  assign hdr_full    = {sr_q[HDR_BITS-2:0], sdi_bit};
  assign data_full   = {sr_q[DATA_W-2:0], sdi_bit};
  assign hdr_is_read = hdr_full[HDR_BITS-1];
  assign rd_addr     = hdr_full[ADDR_W-1:0];

  // Next-state logic
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sr_n    = sr_q;
    rw_n    = rw_q;
    addr_n  = addr_q;
    tx_n    = tx_q;
    bit_n   = bit_q;
    oe_n    = oe_q;
    we_n    = 1'b0;
    wd_n    = wd_q;

    if (cs_rise) begin
      state_n = FR_IDLE;
      oe_n    = 1'b0;
    end else if (cs_fall) begin
      state_n = FR_SHIFT;
      cnt_n   = '0;
      rw_n    = 1'b0;
      oe_n    = 1'b0;
    end else if (state_q == FR_SHIFT) begin
      if (sck_rise) begin
        sr_n  = {sr_q[SR_W-2:0], sdi_bit};
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == CNT_HDR_LAST) begin
          rw_n   = hdr_is_read;
          addr_n = hdr_full[ADDR_W-1:0];
          if (hdr_is_read) begin
            oe_n  = 1'b1;
            bit_n = rd_data[DATA_W-1];
            tx_n  = {rd_data[DATA_W-2:0], 1'b0};
          end
        end
        if (!upd_on_fall && rw_q && (cnt_q >= CNT_HDR) && (cnt_q <= CNT_FRM_PEN)) begin
          bit_n = tx_q[DATA_W-1];
          tx_n  = {tx_q[DATA_W-2:0], 1'b0};
        end
        if (cnt_q == CNT_FRM_LAST) begin
          state_n = FR_DONE;
          if (!rw_q) begin
            we_n = 1'b1;
            wd_n = data_full;
          end
        end
      end else if (sck_fall && upd_on_fall && rw_q && (cnt_q > CNT_HDR)) begin
        bit_n = tx_q[DATA_W-1];
        tx_n  = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      tx_q    <= '0;
      bit_q   <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      wd_q    <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sr_q    <= sr_n;
      rw_q    <= rw_n;
      addr_q  <= addr_n;
      tx_q    <= tx_n;
      bit_q   <= bit_n;
      oe_q    <= oe_n;
      we_q    <= we_n;
      wd_q    <= wd_n;
    end
  end

  assign wr_en   = we_q;
  assign wr_addr = addr_q;
  assign wr_data = wd_q;
  assign sdo_bit = bit_q;
  assign sdo_oe  = oe_q;

endmodule

// File: rtl/sreg_regfile.sv
// Register array: one write port, one asynchronous read port.
module sreg_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '0;
      else if (hit) mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sreg_slave.sv
// Top: pin synchronisation, edge detection, sequencer and register array.
module sreg_slave #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  input  logic out_edge_fall,
  output logic sdo,
  output logic sdo_oe
);

  logic              rst_i_n;
  logic [2:0]        pins_s;
  logic              cs_s, sck_s, sdi_s;
  logic              cs_rise, cs_fall;
  logic              sck_rise, sck_fall;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              sdo_bit;
  logic              oe_int;

  sreg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Chip select idles high, shift clock and data idle low
  sreg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     ({cs_n, sclk, sdi}),
    .q     (pins_s)
  );

  assign cs_s  = pins_s[2];
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[0];

  sreg_edge #(.IDLE_LVL(1'b1)) u_cs_edge (
    .clk   (clk),
    .rst_n (rst_i_n),
    .lvl   (cs_s),
    .rise  (cs_rise),
    .fall  (cs_fall)
  );

  sreg_edge #(.IDLE_LVL(1'b0)) u_sck_edge (
    .clk   (clk),
    .rst_n (rst_i_n),
    .lvl   (sck_s),
    .rise  (sck_rise),
    .fall  (sck_fall)
  );

  sreg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall),
    .sdi_bit     (sdi_s),
    .upd_on_fall (out_edge_fall),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .sdo_bit     (sdo_bit),
    .sdo_oe      (oe_int)
  );

  sreg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign sdo_oe = oe_int;
  assign sdo    = oe_int ? sdo_bit : 1'bz;

endmodule

// File: rtl/sreg_slave_chk.sv
// Property checker attached to the slave top.
module sreg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic cs_rise,
  input logic sck_rise,
  input logic sck_fall,
  input logic out_edge_fall,
  input logic sdo_bit,
  input logic sdo_oe,
  input logic wr_en
);

  // R6: output enable released after chip select rises
  assert_oe_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_oe);

  // R8: a write is only committed by a rising shift edge seen while selected
  assert_wr_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(sck_rise) && !$past(cs_s)));

  // R9: one commit per frame, never back to back
  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4: rising-edge mode only moves data out on a rising edge
  assert_rise_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_edge_fall && sdo_oe && !sck_rise) |=> $stable(sdo_bit));

  // R5: falling-edge mode only moves data out on a falling edge
  assert_fall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_edge_fall && sdo_oe && !sck_fall) |=> $stable(sdo_bit));

endmodule

bind sreg_slave sreg_slave_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_i_n),
  .cs_s          (cs_s),
  .cs_rise       (cs_rise),
  .sck_rise      (sck_rise),
  .sck_fall      (sck_fall),
  .out_edge_fall (out_edge_fall),
  .sdo_bit       (sdo_bit),
  .sdo_oe        (sdo_oe),
  .wr_en         (wr_en)
);

// File: tb/sreg_slave_bench.sv
module sreg_slave_bench;

  localparam int H = 8;  // system clocks per shift-clock half period

  logic clk;
  logic rst_n;
  logic cs_n;
  logic sclk;
  logic sdi;
  logic strap;
  wire  sdo;
  wire  sdo_oe;

  int n_checks;
  int n_fail;
  bit finished;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       samp_ev;

  sreg_slave u_sreg_slave (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .sclk          (sclk),
    .sdi           (sdi),
    .out_edge_fall (strap),
    .sdo           (sdo),
    .sdo_oe        (sdo_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Driver: one host frame of nbits shift periods
  task automatic run_frame(input logic rw, input logic [6:0] a, input logic [7:0] d,
                           input int nbits, input string tag);
    logic [15:0] f;
    f = {rw, a, d};
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? f[15-i] : 1'b1;
      repeat (H) @(negedge clk);
      if (rw && nbits >= 16 && strap && i >= 8 && i < 16) -> samp_ev;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (rw && nbits >= 16 && !strap && i >= 7 && i < 15) -> samp_ev;
      if (!rw && i == 10) check({7'd0, sdo_oe}, 8'd0, {"R6 oe low mid-write ", tag});
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check({7'd0, sdo_oe}, 8'd0, {"R6 oe low after deselect ", tag});
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    run_frame(1'b1, a, 8'h00, 16, tag);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string tag);
    run_frame(1'b0, a, d, 16, tag);
  endtask

  // Shift-clock activity with chip select held high
  task automatic unselected_burst(input logic [15:0] f);
    for (int i = 0; i < 16; i++) begin
      sdi = f[15-i];
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  // Monitor: collects read bits at host sample points, compares to scoreboard
  initial begin
    logic [7:0] got;
    int         nb;
    got = 8'h00;
    nb  = 0;
    forever begin
      @(samp_ev);
      if (sdo_oe !== 1'b1) begin
        n_checks++;
        n_fail++;
        $display("FAIL R6 oe not high during read data: actual %b expected 1", sdo_oe);
      end
      got = {got[6:0], sdo};
      nb++;
      if (nb == 8) begin
        nb = 0;
        if (exp_q.size() == 0) begin
          n_checks++;
          n_fail++;
          $display("FAIL R3 unexpected read byte: actual 0x%02h expected none", got);
        end else begin
          logic [7:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got, e, t);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sclk  = 1'b0;
    sdi   = 1'b0;
    strap = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check({7'd0, sdo_oe}, 8'd0, "R1 oe low after reset");
    do_read(7'h05, 8'h00, "R1 reset value rising mode");
    strap = 1'b1;
    do_read(7'h05, 8'h00, "R1 reset value falling mode");

    // R2/R3/R4/R5: write then read in both output modes
    strap = 1'b0;
    do_write(7'h12, 8'hA5, "R2 write 0x12");
    do_read(7'h12, 8'hA5, "R4 read 0x12 rising-edge update");
    strap = 1'b1;
    do_read(7'h12, 8'hA5, "R5 read 0x12 falling-edge update");

    // R3: boundary addresses
    do_write(7'h00, 8'h3C, "R2 write 0x00");
    do_write(7'h7F, 8'hC3, "R2 write 0x7F");
    do_read(7'h00, 8'h3C, "R3 read lowest address falling");
    strap = 1'b0;
    do_read(7'h7F, 8'hC3, "R3 read highest address rising");
    do_write(7'h55, 8'h81, "R2 write 0x55");
    do_read(7'h55, 8'h81, "R4 read 0x55 edge bits rising");
    strap = 1'b1;
    do_read(7'h55, 8'h81, "R5 read 0x55 edge bits falling");

    // R7: aborted writes leave the target untouched
    run_frame(1'b0, 7'h12, 8'hFF, 12, "R7 abort after 12");
    run_frame(1'b0, 7'h12, 8'h00, 15, "R7 abort after 15");
    run_frame(1'b0, 7'h12, 8'h0F, 8,  "R7 abort after header");
    do_read(7'h12, 8'hA5, "R7 target unchanged after aborts");

    // R8: clocking while deselected does nothing
    unselected_burst({1'b0, 7'h12, 8'h00});
    unselected_burst({1'b0, 7'h00, 8'hEE});
    do_read(7'h12, 8'hA5, "R8 no write while deselected 0x12");
    strap = 1'b0;
    do_read(7'h00, 8'h3C, "R8 no write while deselected 0x00");

    // R9: extra clocks after the frame are ignored
    run_frame(1'b0, 7'h20, 8'h5A, 24, "R9 write with trailing clocks");
    do_read(7'h20, 8'h5A, "R9 value after trailing clocks");
    do_read(7'h7F, 8'hC3, "R9 other register untouched");

    repeat (20) @(negedge clk);
    check(8'(exp_q.size()), 8'd0, "R3 all expected reads observed");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule